// File: doc/BRIEF.md
# Configurable-Edge Serial Peripheral Master

This block is an SPI master driven through a small register write port. Three registers are writable: a clock divider, a control word and a transmit data word. A fourth value, the received shift register, can always be read. Writing the transmit data word while the block is idle starts a transfer. The transfer clocks out a programmed number of bits, most significant bit first, from a left-justified 32-bit word. It asserts the active-low select lines of every slave named in a bitmask and captures MISO into the readback value.

The control word sets four things: the select mask, the bit count, the edge on which MOSI changes and the edge on which MISO is sampled. The two edges are chosen independently, so any of the four SPI clocking modes can be produced. The control word and the divider keep their values from one transfer to the next. Software therefore rewrites only the data word when it sends repeated transfers to the same slave. A busy output covers the whole transfer, from the start write until the selects are released.

Top module: `spi_edge_master`

## Requirements
- R1: After reset, sclk is 0, every ssN bit is 1, busy is 0, mosi is 0 and rdData is 0.
- R2: A write to address 2 (data) while busy is 0 raises busy on the next cycle. Busy then stays high for exactly 2*N*(D+1) cycles, where N is the bit count and D the divider value written at address 0.
- R3: sclk idles low and toggles every D+1 cycles during a transfer. It gives exactly N rising edges per transfer and ends low.
- R4: While busy, ssN equals the inverse of control bits [23:0] and does not change. When idle, ssN is all ones.
- R5: The bit count N is control bits [29:24]. Values 1 to 32 are used as written, and values 0 and 33 to 63 mean 32.
- R6: MOSI sends data bits 31 down to 32-N, most significant first. The first bit is present as soon as busy rises. Control bit 31 set makes MOSI change on falling sclk edges, and clear makes it change on rising edges.
- R7: Control bit 30 set samples MISO on rising sclk edges, and clear samples it on falling edges. Each sampled bit enters rdData at bit 0, and rdData is cleared at the start. After the transfer, rdData holds the N received bits right-justified, first bit highest, and it does not change while idle.
- R8: The control word and the divider keep their values across transfers until they are rewritten.
- R9: Writes to any address while busy is 1 are ignored. This includes a write in the final busy cycle: it neither changes the settings nor starts a new transfer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Register address: 0 divider, 1 control, 2 data |
| wrData | input | 32 | Register write value |
| rdData | output | 32 | Received shift register |
| busy | output | 1 | High for the duration of a transfer |
| sclk | output | 1 | Serial clock, idles low |
| ssN | output | NUM_SS | Active-low slave selects |
| mosi | output | 1 | Serial data to slaves |
| miso | input | 1 | Serial data from slaves |

## Verification
Two events can land in the same cycle. A register write can arrive on the very clock edge on which the final half period ends, busy drops and the selects are released. The bench waits until the final busy cycle of a transfer and drives a data write on that edge, after issuing divider and control writes earlier in the same transfer. It judges the result by the absence of a second busy period and by a following transfer whose timing, select pattern and bit count still match the old settings. Sampling and launching also coincide with sclk edges in every cycle when the divider is zero. The bench's own slave model captures MOSI and drives MISO at the opposite edges for each mode.

// File: rtl/spi_edge_pkg.sv
package spi_edge_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 2;
  localparam int CNT_W  = 6;
  localparam int LEN_LSB    = 24;
  localparam int LAUNCH_BIT = 31;
  localparam int SAMPLE_BIT = 30;
  localparam logic [ADDR_W-1:0] ADDR_DIV  = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_DATA = 2'd2;

  typedef struct packed {
    logic start;
    logic shiftTx;
    logic sampleRx;
    logic finish;
  } spiStrobe_t;
endpackage

// File: rtl/spi_edge_ctrl.sv
module spi_edge_ctrl
  import spi_edge_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startReq,
  input  logic [DIV_W-1:0] divider,
  input  logic [CNT_W-1:0] bitCount,
  input  logic             launchFall,
  input  logic             sampleRise,
  output spiStrobe_t       strb,
  output logic             busy,
  output logic             sclk
);
  logic             active;
  logic             sclkR;
  logic [DIV_W-1:0] divCnt;
  logic [CNT_W-1:0] halfCnt;
  logic [CNT_W:0]   lastHalf;
  logic             halfTick;
  logic             evenHalf;
  logic             isLast;

  // Half periods are numbered 0..2N-1; even ones end in a rising edge.
  assign lastHalf = {bitCount, 1'b0} - 1'b1;
  assign halfTick = active && (divCnt == divider);
  assign evenHalf = !halfCnt[0];
  assign isLast   = ({1'b0, halfCnt} == lastHalf);

  always_comb begin
    strb.start    = startReq;
    strb.finish   = halfTick && isLast;
    strb.sampleRx = halfTick && (sampleRise == evenHalf);
    if (launchFall)
      strb.shiftTx = halfTick && !evenHalf && !isLast;
    else
      strb.shiftTx = halfTick && evenHalf && (halfCnt != '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active  <= 1'b0;
      sclkR   <= 1'b0;
      divCnt  <= '0;
      halfCnt <= '0;
    end else if (startReq) begin
      active  <= 1'b1;
      sclkR   <= 1'b0;
      divCnt  <= '0;
      halfCnt <= '0;
    end else if (halfTick) begin
      divCnt <= '0;
      if (isLast) begin
        active <= 1'b0;
        sclkR  <= 1'b0;
      end else begin
        sclkR   <= ~sclkR;
        halfCnt <= halfCnt + 1'b1;
      end
    end else if (active) begin
      divCnt <= divCnt + 1'b1;
    end
  end

  assign busy = active;
  assign sclk = sclkR;
endmodule

// File: rtl/spi_edge_datapath.sv
module spi_edge_datapath
  import spi_edge_pkg::*;
#(
  parameter int DIV_W  = 16,
  parameter int NUM_SS = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              busy,
  input  spiStrobe_t        strb,
  input  logic              miso,
  output logic              startReq,
  output logic [DIV_W-1:0]  divider,
  output logic [CNT_W-1:0]  bitCount,
  output logic              launchFall,
  output logic              sampleRise,
  output logic              mosi,
  output logic [NUM_SS-1:0] ssN,
  output logic [DATA_W-1:0] rdData
);
  localparam logic [CNT_W-1:0] MAX_BITS = CNT_W'(DATA_W);

  logic [DIV_W-1:0]  divReg;
  logic [DATA_W-1:0] ctrlReg;
  logic [DATA_W-1:0] txShift;
  logic [DATA_W-1:0] rxShift;
  logic [NUM_SS-1:0] ssReg;
  logic [CNT_W-1:0]  lenField;
  logic              writeOk;

  assign writeOk  = wrEn && !busy;
  assign startReq = writeOk && (wrAddr == ADDR_DATA);
  assign lenField = ctrlReg[LEN_LSB +: CNT_W];

  always_comb begin
    if (lenField == '0 || lenField > MAX_BITS) bitCount = MAX_BITS;
    else                                         bitCount = lenField;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divReg  <= '0;
      ctrlReg <= '0;
      txShift <= '0;
      rxShift <= '0;
      ssReg   <= '1;
    end else begin
      if (writeOk && wrAddr == ADDR_DIV)  divReg  <= wrData[DIV_W-1:0];
      if (writeOk && wrAddr == ADDR_CTRL) ctrlReg <= wrData;
      if (strb.start) begin
        txShift <= wrData;
        rxShift <= '0;
        ssReg   <= ~ctrlReg[NUM_SS-1:0];
      end else begin
        if (strb.shiftTx)  txShift <= {txShift[DATA_W-2:0], 1'b0};
        if (strb.sampleRx) rxShift <= {rxShift[DATA_W-2:0], miso};
        if (strb.finish)   ssReg   <= '1;
      end
    end
  end

  assign divider    = divReg;
  assign launchFall = ctrlReg[LAUNCH_BIT];
  assign sampleRise = ctrlReg[SAMPLE_BIT];
  assign mosi       = txShift[DATA_W-1];
  assign ssN        = ssReg;
  assign rdData     = rxShift;
endmodule

// File: rtl/spi_edge_master.sv
module spi_edge_master
  import spi_edge_pkg::*;
#(
  parameter int DIV_W  = 16,
  parameter int NUM_SS = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              busy,
  output logic              sclk,
  output logic [NUM_SS-1:0] ssN,
  output logic              mosi,
  input  logic              miso
);
  spiStrobe_t       strb;
  logic             startReq;
  logic [DIV_W-1:0] divider;
  logic [CNT_W-1:0] bitCount;
  logic             launchFall;
  logic             sampleRise;

  spi_edge_datapath #(.DIV_W(DIV_W), .NUM_SS(NUM_SS)) u_dp (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .busy(busy), .strb(strb), .miso(miso), .startReq(startReq),
    .divider(divider), .bitCount(bitCount), .launchFall(launchFall),
    .sampleRise(sampleRise), .mosi(mosi), .ssN(ssN), .rdData(rdData)
  );

  spi_edge_ctrl #(.DIV_W(DIV_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .divider(divider),
    .bitCount(bitCount), .launchFall(launchFall), .sampleRise(sampleRise),
    .strb(strb), .busy(busy), .sclk(sclk)
  );
endmodule

// File: rtl/spi_edge_master_sva.sv
module spi_edge_master_sva
  import spi_edge_pkg::*;
#(
  parameter int NUM_SS = 24
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [ADDR_W-1:0] wrAddr,
  input logic [DATA_W-1:0] rdData,
  input logic              busy,
  input logic              sclk,
  input logic [NUM_SS-1:0] ssN
);
  p_start_r2: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == ADDR_DATA && !busy) |=> busy);

  p_sclk_idle_r3: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !sclk);

  p_ss_release_r4: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (ssN == '1));

  p_ss_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(ssN));

  p_rd_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && $past(!busy)) |-> $stable(rdData));
endmodule

bind spi_edge_master spi_edge_master_sva #(.NUM_SS(NUM_SS)) u_sva (.*);

// File: tb/spi_edge_master_tb.sv
module spi_edge_master_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_SS = 24;

  typedef struct {
    int          cycles;
    int          n;
    logic [31:0] tx;
    logic [31:0] rx;
    logic [31:0] pat;
    logic [23:0] mask;
    bit          lf;
    bit          sr;
    string       tag;
  } item_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [1:0] wrAddr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic busy, sclk, mosi;
  logic miso = 1'b0;
  logic [NUM_SS-1:0] ssN;

  int checks = 0;
  int errors = 0;
  int cycleCount = 0;
  bit done = 0;

  item_t sb[$];
  logic [31:0] shDiv = 0;
  logic [31:0] shCtrl = 0;

  spi_edge_master #(.DIV_W(16), .NUM_SS(NUM_SS)) u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdData(rdData), .busy(busy), .sclk(sclk), .ssN(ssN), .mosi(mosi),
    .miso(miso)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string req, string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, tag, act, exp);
    end
  endtask

  // Called at a negedge; returns at the next negedge.
  task automatic regWrite(logic [1:0] a, logic [31:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic setDiv(logic [31:0] v);
    regWrite(2'd0, v); shDiv = v;
  endtask

  task automatic setCtrl(logic [31:0] v);
    regWrite(2'd1, v); shCtrl = v;
  endtask

  function automatic item_t mkItem(logic [31:0] data, logic [31:0] pat, string tag);
    item_t it;
    int f;
    logic [63:0] m;
    f = int'(shCtrl[29:24]);
    it.n = (f == 0 || f > 32) ? 32 : f;
    m = (64'd1 << it.n) - 64'd1;
    it.cycles = 2 * it.n * (int'(shDiv[15:0]) + 1);
    it.tx   = 32'(64'(data) >> (32 - it.n));
    it.rx   = 32'(64'(pat) & m);
    it.pat  = pat;
    it.mask = shCtrl[23:0];
    it.lf   = shCtrl[31];
    it.sr   = shCtrl[30];
    it.tag  = tag;
    return it;
  endfunction

  task automatic runXfer(logic [31:0] data, logic [31:0] pat, string tag);
    sb.push_back(mkItem(data, pat, tag));
    regWrite(2'd2, data);
    while (sb.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  // Monitor and slave model, evaluated away from the active edge.
  bit inXfer = 0;
  item_t cur;
  int cnt, samp, rises;
  bit ssOk;
  logic [31:0] txCap;
  logic prevSclk = 1'b0;
  logic prevMosi = 1'b0;

  always @(negedge clk) begin
    if (rstN) begin
      if (busy && !inXfer && sb.size() != 0) begin
        inXfer = 1; cur = sb[0];
        cnt = 0; samp = 0; rises = 0; ssOk = 1; txCap = 0;
        miso = cur.pat[cur.n-1];
      end
      if (inXfer) begin
        logic rose, fell;
        rose = !prevSclk && sclk;
        fell = prevSclk && !sclk;
        if (rose) rises++;
        if (cur.lf ? rose : fell) txCap = {txCap[30:0], prevMosi};
        if (cur.sr ? rose : fell) samp++;
        if ((cur.sr ? fell : rose) && samp < cur.n) miso = cur.pat[cur.n-1-samp];
        if (busy) begin
          cnt++;
          if (ssN !== ~cur.mask) ssOk = 0;
        end else begin
          check("R2 busy cycles", cur.tag, 64'(cnt), 64'(cur.cycles));
          check("R3 rising edges", cur.tag, 64'(rises), 64'(cur.n));
          check("R4 select pattern", cur.tag, 64'(ssOk), 64'd1);
          check("R6 mosi bits", cur.tag, 64'(txCap), 64'(cur.tx));
          check("R7 readback", cur.tag, 64'(rdData), 64'(cur.rx));
          void'(sb.pop_front());
          inXfer = 0;
        end
      end
    end
    prevSclk = sclk;
    prevMosi = mosi;
  end

  always @(posedge clk) begin
    cycleCount++;
    if (cycleCount > 100000 && !done) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected below 100000", cycleCount);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 sclk", "reset", 64'(sclk), 64'd0);
    check("R1 ssN", "reset", 64'(ssN), 64'hFFFFFF);
    check("R1 busy", "reset", 64'(busy), 64'd0);
    check("R1 mosi", "reset", 64'(mosi), 64'd0);
    check("R1 rdData", "reset", 64'(rdData), 64'd0);
    rstN = 1'b1;
    @(negedge clk);

    setDiv(4);
    setCtrl((32'd8 << 24) | 32'h000001);
    runXfer(32'hA5123456, 32'h3C, "R6 rise-launch fall-sample");
    runXfer(32'h5A000000, 32'hC3, "R8 persist");

    setDiv(0);
    setCtrl(32'hC0000000 | (32'd32 << 24) | 32'h800000);
    runXfer(32'hDEADBEEF, 32'h12345678, "R3 div0 mode11");

    setDiv(1);
    setCtrl(32'h80000000 | 32'hFFFFFF);
    runXfer(32'h80017FFE, 32'hCAFEF00D, "R5 field0");

    setDiv(2);
    setCtrl(32'h40000000 | (32'd45 << 24) | 32'h0F0F0F);
    runXfer(32'h13579BDF, 32'h2468ACE0, "R5 field45");

    setCtrl(32'h80000000 | (32'd1 << 24) | 32'h000100);
    runXfer(32'h80000000, 32'h1, "R5 one bit");

    // R9: writes during a transfer, the last one on the finishing edge.
    setDiv(1);
    setCtrl(32'h40000000 | (32'd4 << 24) | 32'h000042);
    begin
      item_t it;
      it = mkItem(32'hB0000000, 32'h9, "R9 collided");
      sb.push_back(it);
      regWrite(2'd2, 32'hB0000000);
      regWrite(2'd0, 32'd9);
      regWrite(2'd1, 32'h00FFFFFF);
      repeat (it.cycles - 3) @(negedge clk);
      regWrite(2'd2, 32'hFFFFFFFF);
      check("R9 no restart", "final-cycle write", 64'(busy), 64'd0);
      repeat (2) @(negedge clk);
      check("R9 still idle", "final-cycle write", 64'(busy), 64'd0);
      check("R9 queue drained", "final-cycle write", 64'(sb.size()), 64'd0);
    end
    runXfer(32'h60000000, 32'h5, "R9 settings kept");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule